// File: doc/BRIEF.md
# Leading-Edge Blanking Window

This block hides the current-limit and fault comparator inputs for a programmable time right after each PWM on-period begins. Turning on a power transistor produces a short burst of ringing and reverse-recovery current. A current comparator would read that burst as an over-current, and a fault comparator as a fault. The block opens a blanking window on every cycle-start pulse, and while the window is open it forces both blanked outputs low. Outside the window the raw comparator levels pass straight through, with no added delay.

The window length comes from a 7-bit field inside a 16-bit control word. Each unit of the field is one 8 ns step. A parameter gives the number of clock cycles in one step, so the window runs from 0 to 127 steps (0 to 1016 ns). A field value of zero turns blanking off. The length is captured when the window opens. A new cycle-start pulse that arrives while a window is open starts the window again from its full length.

Top module: `leb_window`

## Requirements
- R1: The blanking length N is the field ctrl_word[9:3]. Bits 15:10 and 2:0 of ctrl_word have no effect on any output.
- R2: A cycle_start pulse with N > 0 makes blank_active high in the cycle of the pulse and for the following N*CYCLES_PER_STEP-1 cycles, N*CYCLES_PER_STEP cycles in total. blank_active then falls unless a new pulse arrives.
- R3: While blank_active is low, cur_blanked equals cur_raw and flt_blanked equals flt_raw in the same cycle, with no register in the path.
- R4: A cycle_start pulse with N = 0 produces no blanking. If a window is already open, that pulse closes it in the same cycle.
- R5: A cycle_start pulse with N > 0 that arrives while a window is open restarts the window at its full new length, counted from that pulse.
- R6: Changes to ctrl_word while a window is open do not change when that window ends. Only the value present at the opening pulse counts.
- R7: After reset, blank_active is low and both inputs pass through until the first cycle_start.
- R8: While blank_active is high, cur_blanked and flt_blanked are both 0, whatever the raw inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cycle_start | input | 1 | One-cycle pulse at the start of a PWM on-period |
| ctrl_word | input | 16 | Control word; bits 9:3 hold the blanking length in 8 ns steps |
| cur_raw | input | 1 | Raw current-limit comparator output |
| flt_raw | input | 1 | Raw fault comparator output |
| cur_blanked | output | 1 | Current-limit level after blanking |
| flt_blanked | output | 1 | Fault level after blanking |
| blank_active | output | 1 | High while the blanking window is open |

## Verification
On every cycle, the assertions check the masking and pass-through relation between the raw inputs, the blanked outputs and blank_active. They also check that a window can only open on a cycle-start pulse, and that the opening pulse itself is blanked, or not blanked when the field is zero. The exact window length, its restart on a pulse that arrives mid-window, its cancellation by a zero-length pulse, and its insensitivity to control-word changes mid-window all depend on a cycle count. Only the bench's reference model checks those, because it tracks the remaining time cycle by cycle through each scenario.

// File: rtl/leb_pkg.sv
package leb_pkg;
    localparam int CTRL_W    = 16;
    localparam int FIELD_LSB = 3;
    localparam int FIELD_W   = 7;
    localparam int NUM_LANES = 2;
    localparam int FIELD_MAX = (1 << FIELD_W) - 1;

    typedef logic [FIELD_W-1:0] steps_t;
endpackage

// File: rtl/leb_len_decode.sv
module leb_len_decode #(
    parameter int CYCLES_PER_STEP = 2,
    parameter int CNT_W           = 8
) (
    input  logic [leb_pkg::CTRL_W-1:0] ctrl_word,
    output logic [CNT_W-1:0]           len_cycles
);
    import leb_pkg::*;

    steps_t steps;

    always_comb begin
        // R1: only bits 9:3 carry the length
        steps      = ctrl_word[FIELD_LSB +: FIELD_W];
        len_cycles = CNT_W'(steps) * CNT_W'(CYCLES_PER_STEP);
    end
endmodule

// File: rtl/leb_timer.sv
module leb_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len_cycles,
    output logic             active
);
    typedef struct packed {
        logic [CNT_W-1:0] rem;
    } tstate_t;

    tstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            // R4/R5/R6: a pulse reloads (or clears) the remaining time
            if (len_cycles == '0) st_d.rem = '0;
            else                  st_d.rem = len_cycles - 1'b1;
        end else if (st_q.rem != '0) begin
            st_d.rem = st_q.rem - 1'b1;
        end
        active = (start && (len_cycles != '0)) || (!start && (st_q.rem != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/leb_mask.sv
module leb_mask #(
    parameter int LANES = 2
) (
    input  logic             active,
    input  logic [LANES-1:0] raw,
    output logic [LANES-1:0] masked
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign masked[i] = raw[i] & ~active;
    end
endmodule

// File: rtl/leb_window.sv
module leb_window #(
    parameter int CYCLES_PER_STEP = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cycle_start,
    input  logic [leb_pkg::CTRL_W-1:0] ctrl_word,
    input  logic                       cur_raw,
    input  logic                       flt_raw,
    output logic                       cur_blanked,
    output logic                       flt_blanked,
    output logic                       blank_active
);
    import leb_pkg::*;

    localparam int MAX_CYC = FIELD_MAX * CYCLES_PER_STEP;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0]     len_cycles;
    logic [NUM_LANES-1:0] raw_v;
    logic [NUM_LANES-1:0] out_v;

    leb_len_decode #(.CYCLES_PER_STEP(CYCLES_PER_STEP), .CNT_W(CNT_W)) u_dec (
        .ctrl_word  (ctrl_word),
        .len_cycles (len_cycles)
    );

    leb_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cycle_start),
        .len_cycles (len_cycles),
        .active     (blank_active)
    );

    assign raw_v = {flt_raw, cur_raw};

    leb_mask #(.LANES(NUM_LANES)) u_msk (
        .active (blank_active),
        .raw    (raw_v),
        .masked (out_v)
    );

    assign cur_blanked = out_v[0];
    assign flt_blanked = out_v[1];
endmodule

// File: rtl/leb_window_chk.sv
module leb_window_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cycle_start,
    input logic [15:0] ctrl_word,
    input logic        cur_raw,
    input logic        flt_raw,
    input logic        cur_blanked,
    input logic        flt_blanked,
    input logic        blank_active
);
    logic field_nz;
    assign field_nz = |ctrl_word[9:3];

    a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_active |-> (cur_blanked == cur_raw) && (flt_blanked == flt_raw));

    a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
        blank_active |-> !cur_blanked && !flt_blanked);

    a_r2_opens_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && field_nz) |-> blank_active);

    a_r4_zero_no_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && !field_nz) |-> !blank_active);

    a_r2_rise_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank_active) |-> cycle_start);
endmodule

bind leb_window leb_window_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cycle_start  (cycle_start),
    .ctrl_word    (ctrl_word),
    .cur_raw      (cur_raw),
    .flt_raw      (flt_raw),
    .cur_blanked  (cur_blanked),
    .flt_blanked  (flt_blanked),
    .blank_active (blank_active)
);

// File: tb/sim_leb_window.sv
module sim_leb_window;
    localparam int CLK_PERIOD = 10;
    localparam int CPS        = 2;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cycle_start = 0;
    logic [15:0] ctrl_word = 0;
    logic        cur_raw = 0;
    logic        flt_raw = 0;
    logic        cur_blanked, flt_blanked, blank_active;

    int total = 0;
    int bad   = 0;
    int rem   = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    leb_window #(.CYCLES_PER_STEP(CPS)) u0 (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .ctrl_word(ctrl_word),
        .cur_raw(cur_raw), .flt_raw(flt_raw), .cur_blanked(cur_blanked),
        .flt_blanked(flt_blanked), .blank_active(blank_active)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // control word with all non-field bits set (R1)
    function automatic logic [15:0] cw(input int n, input bit noise);
        logic [15:0] w;
        w = noise ? 16'hFC07 : 16'h0000;
        w[9:3] = 7'(n);
        return w;
    endfunction

    task automatic step(input logic st, input logic c, input logic f,
                        input logic [15:0] w, input string tag);
        int  n;
        bit  ea, ec, ef;
        @(negedge clk);
        cycle_start = st; cur_raw = c; flt_raw = f; ctrl_word = w;
        #1;
        n  = int'(w[9:3]);
        ea = (st && n != 0) || (!st && rem > 0);
        ec = c && !ea;
        ef = f && !ea;
        total = total + 1;
        if (blank_active !== ea || cur_blanked !== ec || flt_blanked !== ef) begin
            bad = bad + 1;
            $display("FAIL %s: actual act=%b cur=%b flt=%b expected act=%b cur=%b flt=%b",
                     tag, blank_active, cur_blanked, flt_blanked, ea, ec, ef);
        end
        if (st) rem = (n == 0) ? 0 : n * CPS - 1;
        else if (rem > 0) rem = rem - 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R7: idle after reset, inputs pass through
        step(0, 1, 1, cw(5, 0), "R7");
        step(0, 1, 0, cw(5, 0), "R7");
        step(0, 0, 1, cw(5, 0), "R3");
        // R2: window of 3 steps, inputs held high (R8)
        step(1, 1, 1, cw(3, 0), "R2");
        for (int i = 0; i < 9; i++) step(0, 1, 1, cw(3, 0), "R2");
        // R8: varied raw patterns inside a window
        step(1, 0, 1, cw(4, 0), "R8");
        for (int i = 0; i < 10; i++) step(0, i[0], i[1], cw(4, 0), "R8");
        // R1: noise bits around the field
        step(1, 1, 1, cw(2, 1), "R1");
        for (int i = 0; i < 6; i++) step(0, 1, 1, cw(2, 1), "R1");
        step(1, 1, 1, 16'hFC07, "R1");
        step(0, 1, 1, 16'hFC07, "R1");
        // R4: zero field, then zero pulse cancelling a running window
        step(1, 1, 1, cw(0, 0), "R4");
        step(0, 1, 1, cw(0, 0), "R4");
        step(1, 1, 1, cw(10, 0), "R4");
        step(0, 1, 1, cw(10, 0), "R4");
        step(0, 1, 1, cw(10, 0), "R4");
        step(1, 1, 1, cw(0, 0), "R4");
        for (int i = 0; i < 3; i++) step(0, 1, 1, cw(10, 0), "R4");
        // R5: restart mid-window with a different length
        step(1, 1, 1, cw(3, 0), "R5");
        for (int i = 0; i < 3; i++) step(0, 1, 1, cw(3, 0), "R5");
        step(1, 1, 1, cw(2, 0), "R5");
        for (int i = 0; i < 6; i++) step(0, 1, 1, cw(2, 0), "R5");
        // R6: field changes mid-window do not move its end
        step(1, 1, 1, cw(2, 0), "R6");
        step(0, 1, 1, cw(100, 0), "R6");
        step(0, 1, 1, cw(0, 0), "R6");
        for (int i = 0; i < 4; i++) step(0, 1, 1, cw(50, 0), "R6");
        // R2: maximum field, window of 127 steps
        step(1, 1, 1, cw(127, 0), "R2");
        for (int i = 0; i < 260; i++) step(0, 1, i[0], cw(127, 0), "R2");
        // R2: minimum nonzero field
        step(1, 1, 1, cw(1, 0), "R2");
        for (int i = 0; i < 4; i++) step(0, 1, 1, cw(1, 0), "R2");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule